// File: doc/BRIEF.md
# Splittable Cascaded Byte Timer

The block is a general-purpose up-counter made of four byte-wide counters. A two-bit mode field groups them in one of four ways: a single 32-bit counter, two 16-bit counters, four separate 8-bit counters, or one 16-bit counter (bytes 3:2) next to two 8-bit counters (bytes 1 and 0). Each byte has its own run bit, its own reload value, its own overflow flag and its own interrupt enable. Within a group, the overflow of a lower byte acts as the count enable of the next byte up. The lowest byte of the group decides whether the group runs. Only the highest byte of the group raises a flag when the group wraps.

The counters advance on a per-cycle tick strobe that an external prescaler supplies. A simple synchronous register port writes and reads the control word, the flags, the live count and the reload values. An external SCL-low-timeout event also sets the byte 3 flag, so a bus watchdog can share that interrupt. The interrupt output is the OR of every flag whose enable bit is set.

Top module: `split_byte_timer`

## Requirements
- R1: After reset every register (control, flags, count, reload) reads 0 and irq_o is 0. The register addresses are: 0 control, 1 flags, 2 count, 3 reload. In the count and reload registers, byte n occupies bits 8n+7:8n.
- R2: The control word holds the run bits in [3:0] (bit n is byte n), the mode in [5:4], the global enable in [6] and the interrupt enables in [11:8] (bit 8+n is byte n). In mode 2 (four 8-bit counters), a running byte adds 1 on each clock with tick_i high and holds when tick_i is low.
- R3: A group that is at its all-ones value and receives a count enable loads its reload value on that clock instead of wrapping to 0. On the same clock it sets the flag of its highest byte.
- R4: Mode 0 joins bytes 3..0 into one 32-bit counter. A carry ripples upward within the same clock. Only flag bit 3 is set when the whole counter wraps.
- R5: Mode 1 forms two 16-bit counters from bytes 1:0 and bytes 3:2. Their wraps set flag bits 1 and 3 respectively.
- R6: Mode 3 forms a 16-bit counter from bytes 3:2 and two separate 8-bit counters on bytes 1 and 0. Their wraps set flag bits 3, 1 and 0.
- R7: A group counts only when the run bit of its lowest byte is 1. The run bits of the upper bytes of a joined group have no effect.
- R8: While the global enable is 0, no counter changes on a tick, whatever the run bits say.
- R9: Writing the flags register loads bits [3:0]: a 0 clears the flag and a 1 sets it. A hardware set in the same clock wins over a written 0.
- R10: A clock with scl_timeout_i high sets flag bit 3.
- R11: irq_o is high exactly when some flag is set together with its interrupt enable.
- R12: A write to the count register loads all four bytes, and it takes priority over a tick in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count strobe, one count per clock while high |
| scl_timeout_i | input | 1 | Bus low-timeout event, sets flag 3 |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| irq_o | output | 1 | Interrupt, OR of enabled set flags |

## Verification
A tick, a register write or a timeout event that is present at a clock edge changes the count and the flags at that same edge. Because irq_o is decoded straight from the flag and enable registers, it follows with no extra delay. Read data is combinational from reg_addr_i. The bench therefore drives every input on the falling edge, lets exactly the intended number of rising edges pass, and reads the result on the next falling edge. Carry, reload and flag cases are placed at exact all-ones values so that the edge at which each result is due is known in advance.

// File: rtl/split_tmr_pkg.sv
package split_tmr_pkg;
  localparam int unsigned NUM_BYTES = 4;
  localparam int unsigned ADDR_W    = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_FLAGS  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_COUNT  = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_RELOAD = 2'd3;

  // control word field positions
  localparam int unsigned CTL_RUN_LSB  = 0;
  localparam int unsigned CTL_MODE_LSB = 4;
  localparam int unsigned CTL_EN_BIT   = 6;
  localparam int unsigned CTL_IEN_LSB  = 8;

  typedef enum logic [1:0] {
    MODE_W32     = 2'd0,
    MODE_W16X2   = 2'd1,
    MODE_W8X4    = 2'd2,
    MODE_W16W8W8 = 2'd3
  } tmr_mode_e;
endpackage

// File: rtl/split_tmr_regs.sv
module split_tmr_regs
  import split_tmr_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned DATA_W = NUM_BYTES * BYTE_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic [NUM_BYTES-1:0] flag_set_i,
  output logic [NUM_BYTES-1:0] run_o,
  output tmr_mode_e            mode_o,
  output logic                 en_o,
  output logic [NUM_BYTES-1:0] ien_o,
  output logic [DATA_W-1:0]    reload_o,
  output logic [NUM_BYTES-1:0] flags_o
);
  logic ctrl_wr, flag_wr, rld_wr;
  logic [NUM_BYTES-1:0] flags_d;

  assign ctrl_wr = we_i && (addr_i == ADDR_CTRL);
  assign flag_wr = we_i && (addr_i == ADDR_FLAGS);
  assign rld_wr  = we_i && (addr_i == ADDR_RELOAD);

  // hardware set wins over a written 0
  always_comb begin
    flags_d = flag_wr ? wdata_i[NUM_BYTES-1:0] : flags_o;
    flags_d = flags_d | flag_set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o    <= '0;
      mode_o   <= MODE_W32;
      en_o     <= 1'b0;
      ien_o    <= '0;
      reload_o <= '0;
      flags_o  <= '0;
    end else begin
      if (ctrl_wr) begin
        run_o  <= wdata_i[CTL_RUN_LSB +: NUM_BYTES];
        mode_o <= tmr_mode_e'(wdata_i[CTL_MODE_LSB +: 2]);
        en_o   <= wdata_i[CTL_EN_BIT];
        ien_o  <= wdata_i[CTL_IEN_LSB +: NUM_BYTES];
      end
      if (rld_wr) reload_o <= wdata_i;
      flags_o <= flags_d;
    end
  end
endmodule

// File: rtl/split_tmr_link.sv
module split_tmr_link
  import split_tmr_pkg::*;
(
  input  tmr_mode_e            mode_i,
  output logic [NUM_BYTES-1:0] link_o   // link_o[n]: byte n extends byte n-1
);
  always_comb begin
    unique case (mode_i)
      MODE_W32:     link_o = 4'b1110;
      MODE_W16X2:   link_o = 4'b1010;
      MODE_W8X4:    link_o = 4'b0000;
      MODE_W16W8W8: link_o = 4'b1000;
      default:      link_o = 4'b0000;
    endcase
  end
endmodule

// File: rtl/split_tmr_byte.sv
module split_tmr_byte #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] wr_val_i,
  input  logic              inc_i,
  input  logic              wrap_i,
  input  logic [BYTE_W-1:0] reload_i,
  output logic [BYTE_W-1:0] cnt_o,
  output logic              full_o
);
  assign full_o = (cnt_o == {BYTE_W{1'b1}});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (wr_i)   cnt_o <= wr_val_i;
    else if (wrap_i) cnt_o <= reload_i;
    else if (inc_i)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/split_byte_timer.sv
module split_byte_timer
  import split_tmr_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned DATA_W = NUM_BYTES * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              scl_timeout_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  logic [NUM_BYTES-1:0] run_q, ien_q, flags_q, link, full, inc_c, wrap_c, ovf_c, flag_set;
  tmr_mode_e            tmr_mode;
  logic                 tmr_en, cnt_wr;
  logic [DATA_W-1:0]    reload_q, cnt_q;

  split_tmr_regs #(.BYTE_W(BYTE_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .flag_set_i (flag_set),
    .run_o      (run_q),
    .mode_o     (tmr_mode),
    .en_o       (tmr_en),
    .ien_o      (ien_q),
    .reload_o   (reload_q),
    .flags_o    (flags_q)
  );

  split_tmr_link u_link (
    .mode_i (tmr_mode),
    .link_o (link)
  );

  // carry ripples up; group wrap propagates down from the group's top byte
  always_comb begin
    logic carry, up_link, up_wrap, own;
    carry   = 1'b0;
    for (int n = 0; n < NUM_BYTES; n++) begin
      inc_c[n] = link[n] ? carry : (tick_i && tmr_en && run_q[n]);
      carry    = inc_c[n] && full[n];
    end
    up_link = 1'b0;
    up_wrap = 1'b0;
    for (int n = NUM_BYTES - 1; n >= 0; n--) begin
      own       = inc_c[n] && full[n];
      wrap_c[n] = up_link ? up_wrap : own;
      ovf_c[n]  = !up_link && own;
      up_wrap   = wrap_c[n];
      up_link   = link[n];
    end
  end

  always_comb begin
    flag_set = ovf_c;
    flag_set[NUM_BYTES-1] = ovf_c[NUM_BYTES-1] | scl_timeout_i;
  end

  assign cnt_wr = reg_we_i && (reg_addr_i == ADDR_COUNT);

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_byte
    split_tmr_byte #(.BYTE_W(BYTE_W)) u_byte (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_i     (cnt_wr),
      .wr_val_i (reg_wdata_i[g*BYTE_W +: BYTE_W]),
      .inc_i    (inc_c[g]),
      .wrap_i   (wrap_c[g]),
      .reload_i (reload_q[g*BYTE_W +: BYTE_W]),
      .cnt_o    (cnt_q[g*BYTE_W +: BYTE_W]),
      .full_o   (full[g])
    );
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      ADDR_CTRL: begin
        reg_rdata_o[CTL_RUN_LSB +: NUM_BYTES] = run_q;
        reg_rdata_o[CTL_MODE_LSB +: 2]        = tmr_mode;
        reg_rdata_o[CTL_EN_BIT]               = tmr_en;
        reg_rdata_o[CTL_IEN_LSB +: NUM_BYTES] = ien_q;
      end
      ADDR_FLAGS:  reg_rdata_o[NUM_BYTES-1:0] = flags_q;
      ADDR_COUNT:  reg_rdata_o = cnt_q;
      ADDR_RELOAD: reg_rdata_o = reload_q;
      default:     reg_rdata_o = '0;
    endcase
  end

  assign irq_o = |(flags_q & ien_q);
endmodule

// File: rtl/split_tmr_chk.sv
module split_tmr_chk
  import split_tmr_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned DATA_W = NUM_BYTES * BYTE_W
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 tick_i,
  input logic                 scl_timeout_i,
  input logic                 reg_we_i,
  input logic [ADDR_W-1:0]    reg_addr_i,
  input logic [DATA_W-1:0]    reg_wdata_i,
  input logic                 irq_o,
  input logic [DATA_W-1:0]    cnt,
  input logic [NUM_BYTES-1:0] flags,
  input logic                 en,
  input tmr_mode_e            mode,
  input logic [NUM_BYTES-1:0] run
);
  logic cnt_wr;
  assign cnt_wr = reg_we_i && (reg_addr_i == ADDR_COUNT);

  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && tick_i && run[0] && mode == MODE_W8X4 && !cnt_wr && cnt[BYTE_W-1:0] != {BYTE_W{1'b1}})
    |=> cnt[BYTE_W-1:0] == BYTE_W'($past(cnt[BYTE_W-1:0]) + 1'b1)); // R2
  AST_HOLD_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && !cnt_wr) |=> $stable(cnt)); // R8
  AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !cnt_wr) |=> $stable(cnt)); // R2
  AST_SCL_SETS_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_timeout_i |=> flags[NUM_BYTES-1]); // R10
  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags == '0) |-> !irq_o); // R11
  AST_COUNT_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr |=> cnt == $past(reg_wdata_i)); // R12
endmodule

bind split_byte_timer split_tmr_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .tick_i        (tick_i),
  .scl_timeout_i (scl_timeout_i),
  .reg_we_i      (reg_we_i),
  .reg_addr_i    (reg_addr_i),
  .reg_wdata_i   (reg_wdata_i),
  .irq_o         (irq_o),
  .cnt           (cnt_q),
  .flags         (flags_q),
  .en            (tmr_en),
  .mode          (tmr_mode),
  .run           (run_q)
);

// File: tb/sim_split_byte_timer.sv
module sim_split_byte_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        scl_to = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          checks = 0;
  int          errors = 0;

  always #2.5 clk = ~clk;

  split_byte_timer u0 (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .tick_i        (tick),
    .scl_timeout_i (scl_to),
    .reg_we_i      (we),
    .reg_addr_i    (addr),
    .reg_wdata_i   (wdata),
    .reg_rdata_o   (rdata),
    .irq_o         (irq)
  );

  localparam logic [1:0] A_CTRL = 2'd0, A_FLAGS = 2'd1, A_COUNT = 2'd2, A_RELOAD = 2'd3;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    check(req, rdata, exp);
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic t_reset;
    rd_chk("R1 ctrl", A_CTRL, 32'h0);
    rd_chk("R1 flags", A_FLAGS, 32'h0);
    rd_chk("R1 count", A_COUNT, 32'h0);
    rd_chk("R1 reload", A_RELOAD, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_byte_count;
    wr(A_CTRL, 32'h61);          // run0, mode 2, enable
    wr(A_RELOAD, 32'h0000_0010);
    wr(A_COUNT, 32'h0000_00FD);
    ticks(2);
    rd_chk("R2 count up", A_COUNT, 32'h0000_00FF);
    rd_chk("R3 no flag before wrap", A_FLAGS, 32'h0);
    ticks(1);
    rd_chk("R3 reload", A_COUNT, 32'h0000_0010);
    rd_chk("R3 flag0", A_FLAGS, 32'h1);
    repeat (3) @(negedge clk);
    rd_chk("R2 hold without tick", A_COUNT, 32'h0000_0010);
  endtask

  task automatic t_chain32;
    wr(A_FLAGS, 32'h0);
    wr(A_CTRL, 32'h41);          // run0, mode 0, enable
    wr(A_COUNT, 32'h0000_00FF);
    ticks(1);
    rd_chk("R4 carry", A_COUNT, 32'h0000_0100);
    wr(A_RELOAD, 32'h1122_3344);
    wr(A_COUNT, 32'hFFFF_FFFE);
    ticks(1);
    rd_chk("R4 all ones", A_COUNT, 32'hFFFF_FFFF);
    rd_chk("R4 no flag yet", A_FLAGS, 32'h0);
    ticks(1);
    rd_chk("R4 group reload", A_COUNT, 32'h1122_3344);
    rd_chk("R4 only flag3", A_FLAGS, 32'h8);
  endtask

  task automatic t_split16;
    wr(A_FLAGS, 32'h0);
    wr(A_CTRL, 32'h55);          // run0, run2, mode 1, enable
    wr(A_RELOAD, 32'hAAAA_5555);
    wr(A_COUNT, 32'hFFFE_FFFF);
    ticks(1);
    rd_chk("R5 low wrap", A_COUNT, 32'hFFFF_5555);
    rd_chk("R5 flag1", A_FLAGS, 32'h2);
    ticks(1);
    rd_chk("R5 high wrap", A_COUNT, 32'hAAAA_5556);
    rd_chk("R5 flag3", A_FLAGS, 32'hA);
  endtask

  task automatic t_mode3;
    wr(A_FLAGS, 32'h0);
    wr(A_CTRL, 32'h77);          // run0..2, mode 3, enable
    wr(A_RELOAD, 32'h0102_0304);
    wr(A_COUNT, 32'hFFFF_FFFF);
    ticks(1);
    rd_chk("R6 three groups reload", A_COUNT, 32'h0102_0304);
    rd_chk("R6 flags 3,1,0", A_FLAGS, 32'hB);
  endtask

  task automatic t_run;
    wr(A_CTRL, 32'h4E);          // run1..3 only, mode 0, enable
    wr(A_COUNT, 32'h0000_0100);
    ticks(3);
    rd_chk("R7 upper run ignored", A_COUNT, 32'h0000_0100);
    wr(A_CTRL, 32'h62);          // run1 only, mode 2, enable
    wr(A_COUNT, 32'h0);
    ticks(3);
    rd_chk("R7 own run per byte", A_COUNT, 32'h0000_0300);
  endtask

  task automatic t_global;
    wr(A_CTRL, 32'h2F);          // all run, mode 2, disabled
    wr(A_COUNT, 32'h0102_0304);
    ticks(4);
    rd_chk("R8 disabled hold", A_COUNT, 32'h0102_0304);
  endtask

  task automatic t_flags;
    wr(A_CTRL, 32'h200);         // irq enable byte1 only, disabled
    wr(A_FLAGS, 32'h5);
    rd_chk("R9 write sets", A_FLAGS, 32'h5);
    check("R11 unenabled flags", {31'b0, irq}, 32'h0);
    wr(A_FLAGS, 32'h7);
    check("R11 enabled flag", {31'b0, irq}, 32'h1);
    wr(A_FLAGS, 32'h5);
    check("R11 cleared flag", {31'b0, irq}, 32'h0);
    wr(A_FLAGS, 32'h0);
    rd_chk("R9 write clears", A_FLAGS, 32'h0);
    wr(A_CTRL, 32'h161);         // run0, mode 2, enable, irq enable byte0
    wr(A_RELOAD, 32'h0);
    wr(A_COUNT, 32'h0000_00FF);
    @(negedge clk);
    we = 1'b1; addr = A_FLAGS; wdata = 32'h0; tick = 1'b1;
    @(negedge clk);
    we = 1'b0; tick = 1'b0;
    rd_chk("R9 hardware set wins", A_FLAGS, 32'h1);
    rd_chk("R3 reload to zero", A_COUNT, 32'h0);
    check("R11 irq from overflow", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_scl;
    wr(A_CTRL, 32'h800);         // irq enable byte3 only
    wr(A_FLAGS, 32'h0);
    check("R11 irq low", {31'b0, irq}, 32'h0);
    @(negedge clk);
    scl_to = 1'b1;
    @(negedge clk);
    scl_to = 1'b0;
    rd_chk("R10 timeout flag", A_FLAGS, 32'h8);
    check("R10 timeout irq", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_wr_priority;
    wr(A_CTRL, 32'h6F);          // all run, mode 2, enable
    @(negedge clk);
    we = 1'b1; addr = A_COUNT; wdata = 32'h0000_0055; tick = 1'b1;
    @(negedge clk);
    we = 1'b0; tick = 1'b0;
    rd_chk("R12 write beats tick", A_COUNT, 32'h0000_0055);
    wr(A_CTRL, 32'h0);
    wr(A_COUNT, 32'h89AB_CDEF);
    rd_chk("R12 byte layout", A_COUNT, 32'h89AB_CDEF);
  endtask

  initial begin
    #200_000;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_byte_count();
    t_chain32();
    t_split16();
    t_mode3();
    t_run();
    t_global();
    t_flags();
    t_scl();
    t_wr_priority();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule